// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block carries out the internal program cycles of a small serial non-volatile word memory once a permitted command has been loaded. The command decoder upstream presents an operation code, a word address and a data word, and raises `cmd_armed` when that command is complete and allowed. A falling edge of chip select then starts the cycle. The block times each phase by counting pulses on a free-running `tick` input. It holds a 256 x 16 storage array and applies the erase and program results to that array. The serial clock does not need to run during a cycle.

Four operations are supported. A word erase sets one word to all ones. A word write always erases the word first and then programs it. An array erase sets every word to all ones. An array write runs a full array erase first and then programs every word with the same value. `busy` stays high across both phases of a two-phase operation. Storage changes only at the end of a phase. A ready/busy level is provided for the serial output: it is driven while chip select is high, from the start of a cycle until the first chip-select fall that occurs while the block is ready.

Top module: `nvm_cycle_seq`

## Requirements
- R1: After reset, `busy` and `rb_oe` are 0 and every word reads back as 16'hFFFF.
- R2: A cycle starts only on a clock where `cs` was 1 at the previous clock and is 0 now, `cmd_armed` is 1 and the block is idle. `busy` is 1 from the next clock. A chip-select fall with `cmd_armed` low starts nothing. Operation codes: 0 is word erase, 1 is word write, 2 is array erase, 3 is array write.
- R3: Word erase lasts T_WORD_ERASE ticks. The addressed word then reads 16'hFFFF, other words are unchanged, and `busy` falls on the clock that samples the last tick.
- R4: Word write is an erase phase of T_WORD_ERASE ticks, after which the word reads 16'hFFFF, followed by a program phase of T_WORD_PROG ticks, after which the word reads the data. `busy` stays high throughout.
- R5: Array erase lasts T_ALL_ERASE ticks, after which every word reads 16'hFFFF.
- R6: Array write is an array erase phase of T_ALL_ERASE ticks, after which all words read 16'hFFFF, followed by a program phase of T_ALL_PROG ticks, after which all words read the data. `busy` stays high throughout.
- R7: The stored contents change only on the clock that ends a phase.
- R8: Only `tick` pulses advance a cycle. Clocks without a tick leave `busy` and the remaining time unchanged.
- R9: Chip-select falls with `cmd_armed` high while `busy` is 1 are ignored and leave the stored contents unchanged.
- R10: `rb_oe` equals `cs` ANDed with a poll flag. The poll flag is set when a cycle starts and cleared by a chip-select fall that occurs while the block is idle and does not start a cycle. `rb_out` is the inverse of `busy`.
- R11: The operation, address and data are captured when the cycle starts. Later changes on `cmd_op`, `cmd_addr` and `cmd_data` have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Free-running timing pulse, one clock wide |
| cs | input | 1 | Chip select, synchronous to clk |
| cmd_armed | input | 1 | A complete, permitted command is loaded |
| cmd_op | input | 2 | Operation code (0 word erase, 1 word write, 2 array erase, 3 array write) |
| cmd_addr | input | ADDR_W (8) | Target word address |
| cmd_data | input | DATA_W (16) | Data word to program |
| rd_addr | input | ADDR_W (8) | Read-back address |
| rd_data | output | DATA_W (16) | Stored word at rd_addr |
| busy | output | 1 | A self-timed cycle is in progress |
| rb_out | output | 1 | Ready/busy level (1 = ready) |
| rb_oe | output | 1 | Ready/busy level is to be driven |

## Verification
The bench builds the block with short phase times: 3 ticks for word erase, 2 ticks for word program, and 5 ticks each for array erase and array program. With a tick every third clock, an array write runs about twice as long as an array erase and the longest cycle ends within 30 clocks. This lets every clock of each phase boundary be compared against a queue-based model. It also leaves room for tick pauses, polling and rejected commands in the middle of a cycle, and for writes at addresses 0 and 255.

// File: rtl/nvmseq_pkg.sv
package nvmseq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE_WORD = 2'd0,
    OP_WRITE_WORD = 2'd1,
    OP_ERASE_ALL  = 2'd2,
    OP_WRITE_ALL  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WERASE = 3'd1,
    PH_WPROG  = 3'd2,
    PH_AERASE = 3'd3,
    PH_APROG  = 3'd4
  } phase_e;

endpackage

// File: rtl/cs_fall_det.sv
module cs_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  output logic fall
);

  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b0;
    else        cs_q <= cs;
  end

  assign fall = cs_q & ~cs;

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run & tick & (cnt_q == limit - CW'(1));
  assign cnt_en = clear | (run & tick);

  always_comb begin
    cnt_d = cnt_q;
    if (clear || expire) cnt_d = '0;
    else if (run && tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: without a tick the remaining time does not move
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !clear) |=> $stable(cnt_q));

  // R8: elapsed count stays below the current phase length
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import nvmseq_pkg::*;
#(
  parameter int AW           = 8,
  parameter int DW           = 16,
  parameter int CW           = 8,
  parameter int T_WORD_ERASE = 4,
  parameter int T_WORD_PROG  = 4,
  parameter int T_ALL_ERASE  = 8,
  parameter int T_ALL_PROG   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cmd_armed,
  input  op_e           cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          tick,
  input  logic          phase_done,
  output phase_e        phase,
  output logic          busy,
  output logic          launch,
  output logic [CW-1:0] limit,
  output logic          poll_en,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);

  phase_e        ph_q, ph_d;
  op_e           op_q;
  logic          poll_q, poll_d;

  assign launch = cs_fall & cmd_armed & (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (launch) begin
        case (cmd_op)
          OP_ERASE_WORD, OP_WRITE_WORD: ph_d = PH_WERASE;
          default:                      ph_d = PH_AERASE;
        endcase
      end
      PH_WERASE: if (phase_done) ph_d = (op_q == OP_WRITE_WORD) ? PH_WPROG : PH_IDLE;
      PH_WPROG:  if (phase_done) ph_d = PH_IDLE;
      PH_AERASE: if (phase_done) ph_d = (op_q == OP_WRITE_ALL) ? PH_APROG : PH_IDLE;
      PH_APROG:  if (phase_done) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    poll_d = poll_q;
    if (launch)                           poll_d = 1'b1;
    else if (cs_fall && ph_q == PH_IDLE)  poll_d = 1'b0;
  end

  always_comb begin
    case (ph_q)
      PH_WERASE: limit = CW'(T_WORD_ERASE);
      PH_WPROG:  limit = CW'(T_WORD_PROG);
      PH_AERASE: limit = CW'(T_ALL_ERASE);
      PH_APROG:  limit = CW'(T_ALL_PROG);
      default:   limit = CW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      poll_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      poll_q <= poll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ERASE_WORD;
      addr_q <= '0;
      data_q <= '0;
    end else if (launch) begin
      op_q   <= cmd_op;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  assign phase   = ph_q;
  assign busy    = (ph_q != PH_IDLE);
  assign poll_en = poll_q;

  // R2: a cycle begins only after an armed chip-select fall
  a_r2_start_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall && cmd_armed));

  // R3: a cycle ends only on a tick
  a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));

  // R11: captured operands hold while a cycle runs
  a_r11_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_done) |=> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

  // R4: a two-phase operation keeps busy between its phases
  a_r4_busy_across_phases: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WERASE && phase_done && op_q == OP_WRITE_WORD) |=> busy);

endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvmseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  phase_e        phase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] word_v [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic          we;
    logic [DW-1:0] wv;
    logic [DW-1:0] word_q;

    always_comb begin
      we = 1'b0;
      wv = '1;
      if (commit) begin
        case (phase)
          PH_WERASE: begin we = (addr == AW'(w)); wv = '1;   end
          PH_WPROG:  begin we = (addr == AW'(w)); wv = data; end
          PH_AERASE: begin we = 1'b1;             wv = '1;   end
          PH_APROG:  begin we = 1'b1;             wv = data; end
          default:   begin we = 1'b0;             wv = '1;   end
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '1;
      else if (we) word_q <= wv;
    end

    assign word_v[w] = word_q;
  end

  assign rd_data = word_v[rd_addr];

  // R7: storage is frozen on clocks that do not end a phase
  a_r7_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(rd_addr) -> $stable(rd_data)));

  // R7: commits only happen inside a cycle
  a_r7_commit_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (phase != PH_IDLE));

endmodule

// File: rtl/nvm_cycle_seq.sv
module nvm_cycle_seq
  import nvmseq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int T_WORD_ERASE = 4000,
  parameter int T_WORD_PROG  = 4000,
  parameter int T_ALL_ERASE  = 8000,
  parameter int T_ALL_PROG   = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cs,
  input  logic              cmd_armed,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              rb_out,
  output logic              rb_oe
);

  localparam int MAX_W = (T_WORD_ERASE > T_WORD_PROG) ? T_WORD_ERASE : T_WORD_PROG;
  localparam int MAX_A = (T_ALL_ERASE > T_ALL_PROG) ? T_ALL_ERASE : T_ALL_PROG;
  localparam int MAX_T = (MAX_W > MAX_A) ? MAX_W : MAX_A;
  localparam int CW    = $clog2(MAX_T + 1);

  logic              cs_fall;
  logic              launch;
  logic              phase_done;
  logic              poll_en;
  logic [CW-1:0]     limit;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  phase_e            phase;

  cs_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .fall  (cs_fall)
  );

  seq_ctrl #(
    .AW           (ADDR_W),
    .DW           (DATA_W),
    .CW           (CW),
    .T_WORD_ERASE (T_WORD_ERASE),
    .T_WORD_PROG  (T_WORD_PROG),
    .T_ALL_ERASE  (T_ALL_ERASE),
    .T_ALL_PROG   (T_ALL_PROG)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall),
    .cmd_armed  (cmd_armed),
    .cmd_op     (op_e'(cmd_op)),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .tick       (tick),
    .phase_done (phase_done),
    .phase      (phase),
    .busy       (busy),
    .launch     (launch),
    .limit      (limit),
    .poll_en    (poll_en),
    .addr_q     (addr_q),
    .data_q     (data_q)
  );

  tick_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .clear  (launch),
    .tick   (tick),
    .limit  (limit),
    .expire (phase_done)
  );

  nvm_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (phase_done),
    .phase   (phase),
    .addr    (addr_q),
    .data    (data_q),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign rb_out = ~busy;
  assign rb_oe  = poll_en & cs;

endmodule

// File: tb/nvm_cycle_seq_test.sv
module nvm_cycle_seq_test;

  localparam int TWE = 3, TWP = 2, TAE = 5, TAP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cs = 1'b0;
  logic        cmd_armed = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_addr = 8'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [7:0]  rd_addr = 8'd0;
  logic [15:0] rd_data;
  logic        busy, rb_out, rb_oe;

  int tests = 0, fails = 0, cyc = 0;
  bit tick_en = 1'b1;
  bit done = 1'b0;

  nvm_cycle_seq #(
    .ADDR_W(8), .DATA_W(16),
    .T_WORD_ERASE(TWE), .T_WORD_PROG(TWP), .T_ALL_ERASE(TAE), .T_ALL_PROG(TAP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .cmd_armed(cmd_armed),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .rb_out(rb_out), .rb_oe(rb_oe)
  );

  always #10 clk = ~clk;

  // reference model: queue of pending phases with remaining ticks
  logic [15:0] m_mem [256];
  int          ph_q[$];
  int          rem_q[$];
  bit          m_busy, m_poll, m_csq;
  logic [7:0]  m_addr;
  logic [15:0] m_data;

  task automatic apply_phase(input int k);
    case (k)
      1: m_mem[m_addr] = 16'hFFFF;
      2: m_mem[m_addr] = m_data;
      3: for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
      default: for (int i = 0; i < 256; i++) m_mem[i] = m_data;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_poll = 0; m_csq = 0;
      ph_q.delete(); rem_q.delete();
      for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
    end else begin
      bit was, fall, go;
      was  = m_busy;
      fall = m_csq && !cs;
      m_csq = cs;
      if (was && tick) begin
        rem_q[0] = rem_q[0] - 1;
        if (rem_q[0] == 0) begin
          apply_phase(ph_q[0]);
          void'(ph_q.pop_front());
          void'(rem_q.pop_front());
          if (ph_q.size() == 0) m_busy = 0;
        end
      end
      go = fall && cmd_armed && !was;
      if (go) begin
        m_busy = 1; m_addr = cmd_addr; m_data = cmd_data;
        case (cmd_op)
          2'd0: begin ph_q.push_back(1); rem_q.push_back(TWE); end
          2'd1: begin ph_q.push_back(1); rem_q.push_back(TWE);
                      ph_q.push_back(2); rem_q.push_back(TWP); end
          2'd2: begin ph_q.push_back(3); rem_q.push_back(TAE); end
          default: begin ph_q.push_back(3); rem_q.push_back(TAE);
                         ph_q.push_back(4); rem_q.push_back(TAP); end
        endcase
        m_poll = 1;
      end else if (fall && !was) m_poll = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison, a quarter period after the edge
  always begin
    @(posedge clk);
    cyc++;
    #5;
    if (rst_n && !done) begin
      chk("R2 busy vs model", {31'd0, busy}, {31'd0, m_busy});
      chk("R7 rd_data vs model", {16'd0, rd_data}, {16'd0, m_mem[rd_addr]});
      chk("R10 rb_oe vs model", {31'd0, rb_oe}, {31'd0, m_poll && cs});
      chk("R10 rb_out vs model", {31'd0, rb_out}, {31'd0, !m_busy});
    end
  end

  initial begin : tick_gen
    int div = 0;
    forever begin
      @(negedge clk);
      if (tick_en) begin
        tick = (div == 2);
        div = (div == 2) ? 0 : div + 1;
      end else tick = 1'b0;
    end
  end

  task automatic load(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_armed = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cs = 1'b1;
    @(negedge clk);
    cs = 1'b0;
    @(negedge clk);
    cmd_armed = 1'b0; cmd_op = ~op; cmd_addr = ~a; cmd_data = ~d;   // R11 scramble
  endtask

  task automatic wait_ready();
    int g = 0;
    while (busy && g < 500) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic peek(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 rb_oe after reset", {31'd0, rb_oe}, 32'd0);
    peek(8'd0, v);   chk("R1 word 0", {16'd0, v}, 32'h0000FFFF);
    peek(8'd200, v); chk("R1 word 200", {16'd0, v}, 32'h0000FFFF);

    // R2: chip-select fall without armed command does nothing
    @(negedge clk); cs = 1'b1;
    @(negedge clk); cs = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no start unarmed", {31'd0, busy}, 32'd0);

    // R4 + R11: word write with scrambled operands after load
    rd_addr = 8'd5;
    load(2'd1, 8'd5, 16'h1234);
    chk("R2 busy after armed fall", {31'd0, busy}, 32'd1);
    wait_ready();
    peek(8'd5, v); chk("R4 R11 word write data", {16'd0, v}, 32'h00001234);
    peek(8'd6, v); chk("R4 neighbour untouched", {16'd0, v}, 32'h0000FFFF);

    // R3: word erase
    rd_addr = 8'd5;
    load(2'd0, 8'd5, 16'h0000);
    wait_ready();
    peek(8'd5, v); chk("R3 word erased", {16'd0, v}, 32'h0000FFFF);

    // R4 boundaries: address 0 and 255
    load(2'd1, 8'd0, 16'hA5A5); wait_ready();
    load(2'd1, 8'd255, 16'h0001); wait_ready();
    peek(8'd0, v);   chk("R4 word 0", {16'd0, v}, 32'h0000A5A5);
    peek(8'd255, v); chk("R4 word 255", {16'd0, v}, 32'h00000001);

    // R9: armed fall during busy is ignored
    rd_addr = 8'd11;
    load(2'd1, 8'd10, 16'hAAAA);
    load(2'd1, 8'd11, 16'h5555);
    wait_ready();
    peek(8'd10, v); chk("R9 first write lands", {16'd0, v}, 32'h0000AAAA);
    peek(8'd11, v); chk("R9 rejected write absent", {16'd0, v}, 32'h0000FFFF);
    chk("R9 idle after first cycle", {31'd0, busy}, 32'd0);

    // R10: ready/busy polling
    load(2'd0, 8'd10, 16'h0);
    @(negedge clk); cs = 1'b1;
    #1 chk("R10 oe while polling", {31'd0, rb_oe}, 32'd1);
    chk("R10 busy level", {31'd0, rb_out}, 32'd0);
    wait_ready();
    #1 chk("R10 ready level", {31'd0, rb_out}, 32'd1);
    chk("R10 oe held until fall", {31'd0, rb_oe}, 32'd1);
    @(negedge clk); cs = 1'b0;
    #1 chk("R10 oe off after fall", {31'd0, rb_oe}, 32'd0);
    @(negedge clk); cs = 1'b1;
    @(negedge clk); #1 chk("R10 oe stays off", {31'd0, rb_oe}, 32'd0);
    cs = 1'b0;

    // R8: no ticks, no progress
    rd_addr = 8'd20;
    load(2'd1, 8'd20, 16'h0F0F);
    tick_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 busy held without ticks", {31'd0, busy}, 32'd1);
    peek(8'd20, v); chk("R8 no commit without ticks", {16'd0, v}, 32'h0000FFFF);
    tick_en = 1'b1;
    wait_ready();
    peek(8'd20, v); chk("R8 resumes and completes", {16'd0, v}, 32'h00000F0F);

    // R6: array write
    rd_addr = 8'd128;
    load(2'd3, 8'd0, 16'h3C3C);
    wait_ready();
    peek(8'd0, v);   chk("R6 word 0", {16'd0, v}, 32'h00003C3C);
    peek(8'd128, v); chk("R6 word 128", {16'd0, v}, 32'h00003C3C);
    peek(8'd255, v); chk("R6 word 255", {16'd0, v}, 32'h00003C3C);

    // R5: array erase
    load(2'd2, 8'd0, 16'h0);
    wait_ready();
    peek(8'd10, v);  chk("R5 word 10", {16'd0, v}, 32'h0000FFFF);
    peek(8'd255, v); chk("R5 word 255", {16'd0, v}, 32'h0000FFFF);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule